// File: doc/BRIEF.md
# Bypassable Instruction Buffer with Thread Squash

This block sits between two stages of a multi-threaded in-order pipeline. Each instruction arriving at the current stage goes one of two ways. It can take a shortcut that skips both the buffer and the following stage and lands two stages ahead. Otherwise it is scheduled to be written into the buffer one stage later and taken out again the stage after that. An instruction is identified only by its thread number and its sequence number.

The storage is an age-ordered queue. New entries join at the tail, the oldest entry is visible at the head and can be popped, any single entry can be pulled out by tag wherever it sits, and a thread squash removes every younger entry of that thread. Surviving entries always stay packed together in age order. The buffer reports its occupancy, and the shortcut decision uses the occupancy held at the start of the cycle.

All operations presented in one cycle take effect in a fixed order: squash first, then tag removal, then pop, then insert.

Top module: `ibuf_top`

## Requirements
- R1: `dec_bypass` is 1 exactly when `dec_valid` is 1, the buffer held no entries at the start of the cycle, `stage_blocked[dec_tid]` is 0 and `dn_free` is nonzero. Otherwise it is 0.
- R2: On the shortcut path `dec_go_stage` equals `dec_stage`+2. On the scheduled path `dec_go_stage` equals `dec_stage`+1, and `dec_rm_stage` equals `dec_stage`+2 in both cases.
- R3: `byp_count` rises by exactly one on each clock edge where `dec_bypass` is 1, and holds on every other edge.
- R4: An insert is accepted (`ins_done`=1) only when occupancy after the same cycle's squash, remove and pop is below DEPTH. An accepted entry joins the tail. A refused insert leaves the contents unchanged.
- R5: The head outputs show the oldest entry without consuming it (all zero when empty). A pop removes the head. A pop on an empty buffer has no effect.
- R6: A remove deletes the oldest entry whose thread and sequence number both match, from any position, and raises `rm_hit`. The order of the other entries is kept.
- R7: A remove that matches no entry gives `rm_hit`=0 and leaves occupancy and contents unchanged.
- R8: A squash for thread T and number S deletes every thread-T entry whose sequence number is strictly greater than S (unsigned), and reports how many were deleted on `sq_kill_cnt`. Entries of other threads, and thread-T entries with numbers at or below S, remain in their original age order with no gaps.
- R9: When a squash and an insert arrive in the same cycle, the insert is judged against the occupancy left after the squash.
- R10: `occ_cnt` gives the registered entry count, with `buf_empty` meaning zero entries and `buf_full` meaning DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | An instruction asks for a path decision |
| dec_tid | input | TID_W | Thread of the deciding instruction |
| dec_stage | input | STG_W | Stage number the instruction is in now |
| stage_blocked | input | THREADS | Per-thread blocked flag of the stage two ahead |
| dn_free | input | FREE_W | Free slots in the input buffer of the stage two ahead |
| dec_bypass | output | 1 | Shortcut taken this cycle |
| dec_go_stage | output | STG_W | Next stage the instruction enters |
| dec_rm_stage | output | STG_W | Stage at which a scheduled entry is removed |
| byp_count | output | BYP_W | Count of shortcut decisions |
| ins_valid | input | 1 | Insert request |
| ins_tid | input | TID_W | Thread of the inserted entry |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_done | output | 1 | Insert accepted this cycle |
| pop_valid | input | 1 | Remove the head entry |
| head_valid | output | 1 | Buffer holds at least one entry |
| head_tid | output | TID_W | Thread of the head entry |
| head_seq | output | SEQ_W | Sequence number of the head entry |
| rm_valid | input | 1 | Remove-by-tag request |
| rm_tid | input | TID_W | Thread tag to remove |
| rm_seq | input | SEQ_W | Sequence tag to remove |
| rm_hit | output | 1 | Remove found a matching entry |
| sq_valid | input | 1 | Squash request |
| sq_tid | input | TID_W | Thread being squashed |
| sq_seq | input | SEQ_W | Youngest sequence number that survives |
| sq_kill_cnt | output | CNT_W | Number of entries deleted by this squash |
| occ_cnt | output | CNT_W | Registered occupancy |
| buf_empty | output | 1 | Occupancy is zero |
| buf_full | output | 1 | Occupancy equals DEPTH |

## Verification
The hardest situation to reach is a squash that deletes entries from the middle of a full queue in the same cycle as an insert that would be refused without the squash. The stimulus fills the buffer with one thread's entries, then issues both requests in a single cycle. It confirms the insert is accepted and that the survivors pop out in age order followed by the new entry. A second hard case is a shortcut decision made in the same cycle as an insert into an empty buffer. The bench drives both at once to show that the decision follows the occupancy at the start of the cycle.

// File: rtl/ibuf_pkg.sv
package ibuf_pkg;
    parameter int TID_W = 2;
    parameter int SEQ_W = 8;

    typedef struct packed {
        logic [TID_W-1:0] tid;
        logic [SEQ_W-1:0] seq;
    } ibuf_ent_t;
endpackage

// File: rtl/ibuf_path_sel.sv
module ibuf_path_sel
    import ibuf_pkg::*;
#(
    parameter int CNT_W   = 3,
    parameter int STG_W   = 3,
    parameter int FREE_W  = 2,
    parameter int BYP_W   = 16,
    parameter int THREADS = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [TID_W-1:0]   dec_tid,
    input  logic [STG_W-1:0]   dec_stage,
    input  logic [THREADS-1:0] stage_blocked,
    input  logic [FREE_W-1:0]  dn_free,
    input  logic [CNT_W-1:0]   occ_cnt,
    output logic               dec_bypass,
    output logic [STG_W-1:0]   dec_go_stage,
    output logic [STG_W-1:0]   dec_rm_stage,
    output logic [BYP_W-1:0]   byp_count
);
    typedef struct packed {
        logic [BYP_W-1:0] byp_cnt;
    } sel_st_t;

    sel_st_t st_d, st_q;
    logic    take;

    always_comb begin
        st_d = st_q;
        take = dec_valid && (occ_cnt == '0) && !stage_blocked[dec_tid]
               && (dn_free != '0);
        if (take) st_d.byp_cnt = st_q.byp_cnt + BYP_W'(1);
        dec_go_stage = take ? dec_stage + STG_W'(2) : dec_stage + STG_W'(1);
        dec_rm_stage = dec_stage + STG_W'(2);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign dec_bypass = take;
    assign byp_count  = st_q.byp_cnt;

    // R3
    byp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_bypass |=> $stable(byp_count));

    // R3
    byp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_bypass |=> byp_count != $past(byp_count));
endmodule

// File: rtl/ibuf_store.sv
module ibuf_store
    import ibuf_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ins_valid,
    input  logic [TID_W-1:0] ins_tid,
    input  logic [SEQ_W-1:0] ins_seq,
    output logic             ins_done,
    input  logic             pop_valid,
    output logic             head_valid,
    output logic [TID_W-1:0] head_tid,
    output logic [SEQ_W-1:0] head_seq,
    input  logic             rm_valid,
    input  logic [TID_W-1:0] rm_tid,
    input  logic [SEQ_W-1:0] rm_seq,
    output logic             rm_hit,
    input  logic             sq_valid,
    input  logic [TID_W-1:0] sq_tid,
    input  logic [SEQ_W-1:0] sq_seq,
    output logic [CNT_W-1:0] sq_kill_cnt,
    output logic [CNT_W-1:0] occ_cnt
);
    typedef struct packed {
        ibuf_ent_t [DEPTH-1:0] ents;
        logic [CNT_W-1:0]      cnt;
    } store_st_t;

    store_st_t st_d, st_q;

    ibuf_ent_t [DEPTH-1:0] work;
    ibuf_ent_t [DEPTH-1:0] pack;
    logic [CNT_W-1:0]      n;
    logic [CNT_W-1:0]      k;
    logic [CNT_W-1:0]      kills;
    logic                  hit;
    logic                  ack;

    always_comb begin
        work  = st_q.ents;
        n     = st_q.cnt;
        kills = '0;
        hit   = 1'b0;
        ack   = 1'b0;

        // stage 1: thread squash, survivors packed toward the head
        pack = '0;
        k    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < n) begin
                if (sq_valid && work[IDX_W'(i)].tid == sq_tid
                    && work[IDX_W'(i)].seq > sq_seq) begin
                    kills = kills + CNT_W'(1);
                end else begin
                    pack[k[IDX_W-1:0]] = work[IDX_W'(i)];
                    k = k + CNT_W'(1);
                end
            end
        end
        work = pack;
        n    = k;

        // stage 2: remove the oldest entry matching the tag
        pack = '0;
        k    = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (CNT_W'(i) < n) begin
                if (rm_valid && !hit && work[IDX_W'(i)].tid == rm_tid
                    && work[IDX_W'(i)].seq == rm_seq) begin
                    hit = 1'b1;
                end else begin
                    pack[k[IDX_W-1:0]] = work[IDX_W'(i)];
                    k = k + CNT_W'(1);
                end
            end
        end
        work = pack;
        n    = k;

        // stage 3: pop the head
        if (pop_valid && n != '0) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                work[IDX_W'(i)] = work[IDX_W'(i + 1)];
            end
            work[DEPTH-1] = '0;
            n = n - CNT_W'(1);
        end

        // stage 4: append at the tail if room remains
        if (ins_valid && n < CNT_W'(DEPTH)) begin
            ack = 1'b1;
            work[n[IDX_W-1:0]].tid = ins_tid;
            work[n[IDX_W-1:0]].seq = ins_seq;
            n = n + CNT_W'(1);
        end

        st_d.ents = work;
        st_d.cnt  = n;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ins_done    = ack;
    assign rm_hit      = hit;
    assign sq_kill_cnt = kills;
    assign occ_cnt     = st_q.cnt;
    assign head_valid  = (st_q.cnt != '0);
    assign head_tid    = st_q.ents[0].tid;
    assign head_seq    = st_q.ents[0].seq;

    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ_cnt <= CNT_W'(DEPTH));

    // R4
    ins_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ins_done && !pop_valid && !rm_valid && !sq_valid)
        |=> occ_cnt == $past(occ_cnt) + CNT_W'(1));

    // R7
    rm_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rm_valid && !rm_hit && !pop_valid && !ins_valid && !sq_valid)
        |=> $stable(st_q));

    // R8
    sq_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_valid && !rm_valid && !pop_valid && !ins_valid)
        |=> occ_cnt == $past(occ_cnt) - $past(sq_kill_cnt));

    // R5
    peek_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!pop_valid && !rm_valid && !sq_valid && !ins_valid)
        |=> $stable(head_seq) && $stable(head_tid));
endmodule

// File: rtl/ibuf_top.sv
module ibuf_top
    import ibuf_pkg::*;
#(
    parameter int DEPTH   = 4,
    parameter int STG_W   = 3,
    parameter int FREE_W  = 2,
    parameter int BYP_W   = 16,
    parameter int THREADS = 1 << TID_W,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               dec_valid,
    input  logic [TID_W-1:0]   dec_tid,
    input  logic [STG_W-1:0]   dec_stage,
    input  logic [THREADS-1:0] stage_blocked,
    input  logic [FREE_W-1:0]  dn_free,
    output logic               dec_bypass,
    output logic [STG_W-1:0]   dec_go_stage,
    output logic [STG_W-1:0]   dec_rm_stage,
    output logic [BYP_W-1:0]   byp_count,
    input  logic               ins_valid,
    input  logic [TID_W-1:0]   ins_tid,
    input  logic [SEQ_W-1:0]   ins_seq,
    output logic               ins_done,
    input  logic               pop_valid,
    output logic               head_valid,
    output logic [TID_W-1:0]   head_tid,
    output logic [SEQ_W-1:0]   head_seq,
    input  logic               rm_valid,
    input  logic [TID_W-1:0]   rm_tid,
    input  logic [SEQ_W-1:0]   rm_seq,
    output logic               rm_hit,
    input  logic               sq_valid,
    input  logic [TID_W-1:0]   sq_tid,
    input  logic [SEQ_W-1:0]   sq_seq,
    output logic [CNT_W-1:0]   sq_kill_cnt,
    output logic [CNT_W-1:0]   occ_cnt,
    output logic               buf_empty,
    output logic               buf_full
);
    localparam int IDX_W = $clog2(DEPTH);

    ibuf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk, .rst_n,
        .ins_valid, .ins_tid, .ins_seq, .ins_done,
        .pop_valid, .head_valid, .head_tid, .head_seq,
        .rm_valid, .rm_tid, .rm_seq, .rm_hit,
        .sq_valid, .sq_tid, .sq_seq, .sq_kill_cnt,
        .occ_cnt
    );

    ibuf_path_sel #(.CNT_W(CNT_W), .STG_W(STG_W), .FREE_W(FREE_W),
                    .BYP_W(BYP_W), .THREADS(THREADS)) u_sel (
        .clk, .rst_n,
        .dec_valid, .dec_tid, .dec_stage, .stage_blocked, .dn_free,
        .occ_cnt,
        .dec_bypass, .dec_go_stage, .dec_rm_stage, .byp_count
    );

    assign buf_empty = (occ_cnt == '0);
    assign buf_full  = (occ_cnt == CNT_W'(DEPTH));

    // R10
    empty_full_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(buf_empty && buf_full));
endmodule

// File: tb/ibuf_top_bench.sv
module ibuf_top_bench;
    import ibuf_pkg::*;

    localparam int DEPTH = 4;
    localparam int STG_W = 3;
    localparam int FREE_W = 2;
    localparam int BYP_W = 16;
    localparam int THREADS = 1 << TID_W;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int NVEC = 14;

    // vector: op[26:24] tid[23:22] seq[21:14] aux[13:11] cnt[10:8] head[7:0]
    // op: 0 idle, 1 insert, 2 pop, 3 remove, 4 squash
    localparam logic [26:0] TBL [NVEC] = '{
        {3'd1, 2'd0, 8'd10, 3'd1, 3'd1, 8'd10},  // R4 append
        {3'd1, 2'd1, 8'd20, 3'd1, 3'd2, 8'd10},  // R4
        {3'd1, 2'd0, 8'd11, 3'd1, 3'd3, 8'd10},  // R4
        {3'd1, 2'd1, 8'd21, 3'd1, 3'd4, 8'd10},  // R4 now full
        {3'd1, 2'd2, 8'd30, 3'd0, 3'd4, 8'd10},  // R4 refused when full
        {3'd3, 2'd1, 8'd20, 3'd1, 3'd3, 8'd10},  // R6 middle removal
        {3'd3, 2'd3, 8'd99, 3'd0, 3'd3, 8'd10},  // R7 no match
        {3'd2, 2'd0, 8'd0,  3'd0, 3'd2, 8'd11},  // R5 pop
        {3'd1, 2'd0, 8'd12, 3'd1, 3'd3, 8'd11},  // R4
        {3'd1, 2'd1, 8'd22, 3'd1, 3'd4, 8'd11},  // R4
        {3'd4, 2'd0, 8'd11, 3'd1, 3'd3, 8'd11},  // R8 keeps equal seq
        {3'd4, 2'd1, 8'd20, 3'd2, 3'd1, 8'd11},  // R8 two killed
        {3'd3, 2'd0, 8'd11, 3'd1, 3'd0, 8'd0},   // R6 last entry
        {3'd2, 2'd0, 8'd0,  3'd0, 3'd0, 8'd0}    // R5 pop on empty
    };

    logic               clk = 1'b0;
    logic               rst_n;
    logic               dec_valid;
    logic [TID_W-1:0]   dec_tid;
    logic [STG_W-1:0]   dec_stage;
    logic [THREADS-1:0] stage_blocked;
    logic [FREE_W-1:0]  dn_free;
    logic               dec_bypass;
    logic [STG_W-1:0]   dec_go_stage;
    logic [STG_W-1:0]   dec_rm_stage;
    logic [BYP_W-1:0]   byp_count;
    logic               ins_valid;
    logic [TID_W-1:0]   ins_tid;
    logic [SEQ_W-1:0]   ins_seq;
    logic               ins_done;
    logic               pop_valid;
    logic               head_valid;
    logic [TID_W-1:0]   head_tid;
    logic [SEQ_W-1:0]   head_seq;
    logic               rm_valid;
    logic [TID_W-1:0]   rm_tid;
    logic [SEQ_W-1:0]   rm_seq;
    logic               rm_hit;
    logic               sq_valid;
    logic [TID_W-1:0]   sq_tid;
    logic [SEQ_W-1:0]   sq_seq;
    logic [CNT_W-1:0]   sq_kill_cnt;
    logic [CNT_W-1:0]   occ_cnt;
    logic               buf_empty;
    logic               buf_full;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    ibuf_top #(.DEPTH(DEPTH), .STG_W(STG_W), .FREE_W(FREE_W), .BYP_W(BYP_W))
    u_ibuf_top (
        .clk, .rst_n, .dec_valid, .dec_tid, .dec_stage, .stage_blocked,
        .dn_free, .dec_bypass, .dec_go_stage, .dec_rm_stage, .byp_count,
        .ins_valid, .ins_tid, .ins_seq, .ins_done, .pop_valid, .head_valid,
        .head_tid, .head_seq, .rm_valid, .rm_tid, .rm_seq, .rm_hit,
        .sq_valid, .sq_tid, .sq_seq, .sq_kill_cnt, .occ_cnt, .buf_empty,
        .buf_full
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_all;
        dec_valid = 1'b0; dec_tid = '0; dec_stage = '0;
        stage_blocked = '0; dn_free = '0;
        ins_valid = 1'b0; ins_tid = '0; ins_seq = '0;
        pop_valid = 1'b0;
        rm_valid = 1'b0; rm_tid = '0; rm_seq = '0;
        sq_valid = 1'b0; sq_tid = '0; sq_seq = '0;
    endtask

    task automatic put(input int t, input int s);
        ins_valid = 1'b1; ins_tid = TID_W'(t); ins_seq = SEQ_W'(s);
        tick;
        ins_valid = 1'b0;
    endtask

    task automatic pop_one;
        pop_valid = 1'b1;
        tick;
        pop_valid = 1'b0;
    endtask

    task automatic decide(input int t, input int blk, input int fr);
        dec_valid = 1'b1; dec_tid = TID_W'(t); dec_stage = STG_W'(3);
        stage_blocked = THREADS'(blk); dn_free = FREE_W'(fr);
        #1;
    endtask

    initial begin
        #(4 * 200000);
        $display("FAIL watchdog expired actual=0 expected=1");
        failures++;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_all();
        rst_n = 1'b0;
        repeat (3) tick;
        rst_n = 1'b1;

        // reset state (R10, R3, R5)
        chk("R10 reset occ", int'(occ_cnt), 0);
        chk("R10 reset empty", int'(buf_empty), 1);
        chk("R10 reset full", int'(buf_full), 0);
        chk("R3 reset byp_count", int'(byp_count), 0);
        chk("R5 reset head_valid", int'(head_valid), 0);

        // shortcut decisions on an empty buffer (R1, R2, R3)
        decide(1, 0, 2);
        chk("R1 all clear", int'(dec_bypass), 1);
        chk("R2 go stage bypass", int'(dec_go_stage), 5);
        tick;
        chk("R3 count after bypass", int'(byp_count), 1);
        decide(1, 2, 2);
        chk("R1 own thread blocked", int'(dec_bypass), 0);
        chk("R2 go stage scheduled", int'(dec_go_stage), 4);
        chk("R2 remove stage", int'(dec_rm_stage), 5);
        tick;
        chk("R3 hold on refusal", int'(byp_count), 1);
        decide(2, 2, 1);
        chk("R1 other thread blocked", int'(dec_bypass), 1);
        tick;
        chk("R3 count second", int'(byp_count), 2);
        decide(0, 0, 0);
        chk("R1 no free slot", int'(dec_bypass), 0);
        tick;
        // same-cycle insert does not affect the decision (R10)
        decide(0, 0, 1);
        ins_valid = 1'b1; ins_tid = '0; ins_seq = 8'd5;
        #1;
        chk("R10 start-of-cycle occupancy", int'(dec_bypass), 1);
        tick;
        ins_valid = 1'b0;
        chk("R3 count third", int'(byp_count), 3);
        #1;
        chk("R1 buffer not empty", int'(dec_bypass), 0);
        tick;
        idle_all();
        chk("R3 hold when idle", int'(byp_count), 3);
        pop_one();
        chk("R5 drained", int'(occ_cnt), 0);

        // vector table
        for (int r = 0; r < NVEC; r++) begin
            logic [26:0] v;
            v = TBL[r];
            case (v[26:24])
                3'd1: begin ins_valid = 1'b1; ins_tid = v[23:22]; ins_seq = v[21:14]; end
                3'd2: pop_valid = 1'b1;
                3'd3: begin rm_valid = 1'b1; rm_tid = v[23:22]; rm_seq = v[21:14]; end
                3'd4: begin sq_valid = 1'b1; sq_tid = v[23:22]; sq_seq = v[21:14]; end
                default: ;
            endcase
            #1;
            if (v[26:24] == 3'd1) chk($sformatf("R4 row %0d ins_done", r), int'(ins_done), int'(v[13:11]));
            if (v[26:24] == 3'd3) chk($sformatf("R6/R7 row %0d rm_hit", r), int'(rm_hit), int'(v[13:11]));
            if (v[26:24] == 3'd4) chk($sformatf("R8 row %0d kills", r), int'(sq_kill_cnt), int'(v[13:11]));
            tick;
            idle_all();
            chk($sformatf("R10 row %0d occ", r), int'(occ_cnt), int'(v[10:8]));
            chk($sformatf("R5 row %0d head", r), int'(head_seq), int'(v[7:0]));
        end
        chk("R10 full flag at end", int'(buf_full), 0);

        // squash closes gaps in age order (R8)
        put(0, 40); put(1, 50); put(0, 41); put(1, 51);
        chk("R10 full flag", int'(buf_full), 1);
        sq_valid = 1'b1; sq_tid = '0; sq_seq = 8'd40;
        #1;
        chk("R8 kill one", int'(sq_kill_cnt), 1);
        tick;
        idle_all();
        chk("R8 occ after squash", int'(occ_cnt), 3);
        chk("R8 head kept", int'(head_seq), 40);
        pop_one();
        chk("R8 second survivor", int'(head_seq), 50);
        chk("R8 second tid", int'(head_tid), 1);
        pop_one();
        chk("R8 third survivor", int'(head_seq), 51);
        pop_one();
        chk("R5 empty again", int'(buf_empty), 1);

        // squash and insert together on a full buffer (R9)
        put(0, 60); put(0, 61); put(0, 62); put(0, 63);
        sq_valid = 1'b1; sq_tid = '0; sq_seq = 8'd61;
        ins_valid = 1'b1; ins_tid = 2'd1; ins_seq = 8'd70;
        #1;
        chk("R9 insert accepted", int'(ins_done), 1);
        chk("R9 kills", int'(sq_kill_cnt), 2);
        tick;
        idle_all();
        chk("R9 occ", int'(occ_cnt), 3);
        pop_one();
        chk("R9 order 61", int'(head_seq), 61);
        pop_one();
        chk("R9 new entry at tail", int'(head_seq), 70);
        chk("R9 new entry tid", int'(head_tid), 1);
        pop_one();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule